// File: doc/BRIEF.md
# Working Register File with Pointer Pairs

This block is the general-purpose register storage of a small 8-bit processor core. It holds 32 byte-wide registers. Two read ports are combinational and supply the ALU operands. One write port stores the result on the rising clock edge. A whole read, execute and writeback step therefore fits in one clock cycle.

The top six registers also act as three 16-bit address pointers. A separate pointer port selects one of the three pairs, returns it as a 16-bit word, and can write a new 16-bit value back into both bytes in the same edge. This serves address calculation for data accesses. The highest pair is also driven at all times onto a dedicated program-memory address output, for table lookups.

Pointer arithmetic, the ALU and memory-mapped access to the registers lie outside this block.

Top module: `wreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 32 registers to zero. Every read output is zero in the cycle after that edge.
- R2: Each of the two byte read ports returns, combinationally and independently, the register addressed by its 5-bit index.
- R3: When `wr_en` is high at a rising edge, the register at `wr_idx` takes `wr_data`. The new value is readable from the following cycle.
- R4: A read of a register in the same cycle it is being written returns the value it held before that write.
- R5: `ptr_sel` codes are 0 = pair 26/27, 1 = pair 28/29 and 2 = pair 30/31. The even register is the low byte. `ptr_rd_data` is {odd register, even register} for the selected pair.
- R6: When `ptr_wr_en` is high with a valid `ptr_sel` at a rising edge, `ptr_wr_data[7:0]` goes to the even register and `ptr_wr_data[15:8]` goes to the odd register of the pair, both at that edge.
- R7: `ptr_sel` = 3 selects no pair. `ptr_rd_data` reads zero, and a pointer write with that code changes no register.
- R8: If a byte write and a pointer write hit the same register at one edge, that register takes the byte value. The other byte of the pair still takes its half of the pointer value.
- R9: `prog_addr` always equals {register 31, register 30}, whatever `ptr_sel` is.
- R10: A register that is not the target of any write at an edge keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write value |
| ptr_sel | input | 2 | Pointer pair select (0, 1, 2; 3 = none) |
| ptr_rd_data | output | 16 | Selected pointer value |
| ptr_wr_en | input | 1 | Pointer write enable |
| ptr_wr_data | input | 16 | Pointer write value |
| prog_addr | output | 16 | Highest pointer pair, as a program-memory address |

## Verification
All storage is visible combinationally, so a wrong register value shows at a read port in the same cycle the index points at it. A wrong write shows one cycle after the faulty edge. The reference model is compared against all four outputs every cycle, with random indices, so a wrong byte lane, a swapped pair half or a lost write priority is caught within a cycle of being read. An output that follows a write too early shows up as a mismatch when the write and the read address the same register.

// File: rtl/wreg_pkg.sv
package wreg_pkg;

    localparam int DEF_N_REGS   = 32;
    localparam int DEF_REG_W    = 8;
    localparam int DEF_N_PTRS   = 3;
    localparam int DEF_PTR_BASE = 26;

    // pointer pair select codes
    typedef enum logic [1:0] {
        PSEL_LOW  = 2'd0,
        PSEL_MID  = 2'd1,
        PSEL_HIGH = 2'd2,
        PSEL_NONE = 2'd3
    } psel_e;

endpackage

// File: rtl/wreg_ptr_map.sv
module wreg_ptr_map #(
    parameter int N_REGS   = wreg_pkg::DEF_N_REGS,
    parameter int N_PTRS   = wreg_pkg::DEF_N_PTRS,
    parameter int PTR_BASE = wreg_pkg::DEF_PTR_BASE,
    localparam int IDX_W   = $clog2(N_REGS),
    localparam int SEL_W   = $clog2(N_PTRS + 1)
) (
    input  logic [SEL_W-1:0] sel,
    output logic             valid,
    output logic [IDX_W-1:0] lo_idx,
    output logic [IDX_W-1:0] hi_idx
);

    // pairs start at an even index, low byte first
    always_comb begin
        valid  = (int'(sel) < N_PTRS);
        lo_idx = '0;
        if (valid) begin
            lo_idx = IDX_W'(PTR_BASE + 2 * int'(sel));
        end
        hi_idx = {lo_idx[IDX_W-1:1], 1'b1};
    end

endmodule

// File: rtl/wreg_store.sv
module wreg_store #(
    parameter int N_REGS = wreg_pkg::DEF_N_REGS,
    parameter int REG_W  = wreg_pkg::DEF_REG_W,
    localparam int IDX_W = $clog2(N_REGS),
    localparam int PTR_W = 2 * REG_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         byte_we,
    input  logic [IDX_W-1:0]             byte_idx,
    input  logic [REG_W-1:0]             byte_val,
    input  logic                         pair_we,
    input  logic [IDX_W-1:0]             pair_lo,
    input  logic [IDX_W-1:0]             pair_hi,
    input  logic [PTR_W-1:0]             pair_val,
    output logic [N_REGS-1:0][REG_W-1:0] regs
);

    typedef struct packed {
        logic [N_REGS-1:0][REG_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            // pair first, so a byte write to the same register overrides it
            if (pair_we) begin
                st_d.regs[pair_lo] = pair_val[REG_W-1:0];
                st_d.regs[pair_hi] = pair_val[PTR_W-1:REG_W];
            end
            if (byte_we) begin
                st_d.regs[byte_idx] = byte_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.regs;

endmodule

// File: rtl/wreg_rd_port.sv
module wreg_rd_port #(
    parameter int N_REGS = wreg_pkg::DEF_N_REGS,
    parameter int REG_W  = wreg_pkg::DEF_REG_W,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic [N_REGS-1:0][REG_W-1:0] regs,
    input  logic [IDX_W-1:0]             idx,
    output logic [REG_W-1:0]             data
);

    always_comb begin
        data = regs[idx];
    end

endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
    parameter int N_REGS   = wreg_pkg::DEF_N_REGS,
    parameter int REG_W    = wreg_pkg::DEF_REG_W,
    parameter int N_PTRS   = wreg_pkg::DEF_N_PTRS,
    parameter int PTR_BASE = wreg_pkg::DEF_PTR_BASE,
    localparam int IDX_W   = $clog2(N_REGS),
    localparam int PTR_W   = 2 * REG_W,
    localparam int SEL_W   = $clog2(N_PTRS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [REG_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [REG_W-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] ptr_sel,
    output logic [PTR_W-1:0] ptr_rd_data,
    input  logic             ptr_wr_en,
    input  logic [PTR_W-1:0] ptr_wr_data,
    output logic [PTR_W-1:0] prog_addr
);

    localparam int N_RD   = 2;
    localparam int TOP_LO = PTR_BASE + 2 * (N_PTRS - 1);

    logic [N_REGS-1:0][REG_W-1:0] regs;
    logic                         sel_ok;
    logic [IDX_W-1:0]             sel_lo, sel_hi;
    logic [N_RD-1:0][IDX_W-1:0]   rd_idx;
    logic [N_RD-1:0][REG_W-1:0]   rd_val;

    wreg_ptr_map #(
        .N_REGS(N_REGS), .N_PTRS(N_PTRS), .PTR_BASE(PTR_BASE)
    ) u_map (
        .sel(ptr_sel), .valid(sel_ok), .lo_idx(sel_lo), .hi_idx(sel_hi)
    );

    wreg_store #(
        .N_REGS(N_REGS), .REG_W(REG_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .byte_we  (wr_en),
        .byte_idx (wr_idx),
        .byte_val (wr_data),
        .pair_we  (ptr_wr_en && sel_ok),
        .pair_lo  (sel_lo),
        .pair_hi  (sel_hi),
        .pair_val (ptr_wr_data),
        .regs     (regs)
    );

    assign rd_idx = {rd_b_idx, rd_a_idx};

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        wreg_rd_port #(
            .N_REGS(N_REGS), .REG_W(REG_W)
        ) u_rd (
            .regs(regs), .idx(rd_idx[p]), .data(rd_val[p])
        );
    end

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];

    always_comb begin
        ptr_rd_data = '0;
        if (sel_ok) begin
            ptr_rd_data = {regs[sel_hi], regs[sel_lo]};
        end
        prog_addr = {regs[TOP_LO + 1], regs[TOP_LO]};
    end

endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
    parameter int N_REGS   = wreg_pkg::DEF_N_REGS,
    parameter int REG_W    = wreg_pkg::DEF_REG_W,
    parameter int N_PTRS   = wreg_pkg::DEF_N_PTRS,
    parameter int PTR_BASE = wreg_pkg::DEF_PTR_BASE,
    localparam int IDX_W   = $clog2(N_REGS),
    localparam int PTR_W   = 2 * REG_W,
    localparam int SEL_W   = $clog2(N_PTRS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] rd_a_idx,
    input logic [REG_W-1:0] rd_a_data,
    input logic [IDX_W-1:0] rd_b_idx,
    input logic [REG_W-1:0] rd_b_data,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [REG_W-1:0] wr_data,
    input logic [SEL_W-1:0] ptr_sel,
    input logic [PTR_W-1:0] ptr_rd_data,
    input logic             ptr_wr_en,
    input logic [PTR_W-1:0] ptr_wr_data,
    input logic [PTR_W-1:0] prog_addr
);

    localparam int TOP_LO = PTR_BASE + 2 * (N_PTRS - 1);

    logic             armed;
    logic             p_rst, p_wr_en, p_pwe;
    logic [IDX_W-1:0] p_wr_idx, p_plo, p_rd_b_idx;
    logic [REG_W-1:0] p_wr_data, p_rd_b_data;
    logic [SEL_W-1:0] p_sel;
    logic [PTR_W-1:0] p_pdata;

    always_ff @(posedge clk) begin
        armed       <= 1'b1;
        p_rst       <= rst;
        p_wr_en     <= wr_en;
        p_wr_idx    <= wr_idx;
        p_wr_data   <= wr_data;
        p_pwe       <= ptr_wr_en && (int'(ptr_sel) < N_PTRS);
        p_plo       <= IDX_W'(PTR_BASE + 2 * int'(ptr_sel));
        p_sel       <= ptr_sel;
        p_pdata     <= ptr_wr_data;
        p_rd_b_idx  <= rd_b_idx;
        p_rd_b_data <= rd_b_data;
    end

    // R1: everything reads zero right after a reset edge
    a_r1_reset_clears: assert property (@(posedge clk)
        (armed && p_rst) |-> (rd_a_data == '0 && rd_b_data == '0 &&
                              ptr_rd_data == '0 && prog_addr == '0));

    // R3: a byte write is readable in the next cycle
    a_r3_byte_write: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_rst && p_wr_en && rd_a_idx == p_wr_idx) |-> rd_a_data == p_wr_data);

    // R6: a pointer write lands in both bytes at once
    a_r6_pair_write: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_rst && p_pwe && ptr_sel == p_sel &&
         !(p_wr_en && p_wr_idx[IDX_W-1:1] == p_plo[IDX_W-1:1]))
        |-> ptr_rd_data == p_pdata);

    // R7: the unused select code reads zero
    a_r7_no_pair: assert property (@(posedge clk) disable iff (rst)
        (int'(ptr_sel) >= N_PTRS) |-> ptr_rd_data == '0);

    // R8: the partner byte still takes its pointer half on a collision
    a_r8_partner_byte: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_rst && p_wr_en && p_pwe &&
         p_wr_idx[IDX_W-1:1] == p_plo[IDX_W-1:1] &&
         rd_b_idx == {p_wr_idx[IDX_W-1:1], ~p_wr_idx[0]})
        |-> rd_b_data == (p_wr_idx[0] ? p_pdata[REG_W-1:0] : p_pdata[PTR_W-1:REG_W]));

    // R9: the program address follows a write to the top pair
    a_r9_prog_addr: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_rst && p_pwe && p_plo == IDX_W'(TOP_LO) &&
         !(p_wr_en && p_wr_idx >= IDX_W'(TOP_LO)))
        |-> prog_addr == p_pdata);

    // R10: an untouched register holds its value
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_rst && rd_b_idx == p_rd_b_idx &&
         !(p_wr_en && p_wr_idx == p_rd_b_idx) &&
         !(p_pwe && p_plo[IDX_W-1:1] == p_rd_b_idx[IDX_W-1:1]))
        |-> rd_b_data == p_rd_b_data);

endmodule

bind wreg_file wreg_file_chk #(
    .N_REGS(N_REGS), .REG_W(REG_W), .N_PTRS(N_PTRS), .PTR_BASE(PTR_BASE)
) u_chk (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_rd_data(ptr_rd_data),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .prog_addr(prog_addr)
);

// File: tb/wreg_file_test.sv
`timescale 1ns/1ps
module wreg_file_test;
    import wreg_pkg::*;

    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [7:0]  rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, ptr_wr_en = 1'b0;
    logic [1:0]  ptr_sel = 2'd0;
    logic [15:0] ptr_rd_data, ptr_wr_data = '0, prog_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:0] m [32];

    always #5 clk = ~clk;

    wreg_file uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ptr_sel(ptr_sel), .ptr_rd_data(ptr_rd_data),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .prog_addr(prog_addr)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ptr(logic [1:0] s);
        if (s == PSEL_NONE) return 16'h0;
        return {m[27 + 2 * s], m[26 + 2 * s]};
    endfunction

    // compare all outputs with the model, then take one clock edge
    task automatic tick(string tag);
        #1;
        chk(tag, "rd_a", {8'h0, rd_a_data}, {8'h0, m[rd_a_idx]});
        chk(tag, "rd_b", {8'h0, rd_b_data}, {8'h0, m[rd_b_idx]});
        chk(tag, "ptr",  ptr_rd_data, exp_ptr(ptr_sel));
        chk(tag, "prog", prog_addr, {m[31], m[30]});
        @(posedge clk);
        if (rst) begin
            foreach (m[i]) m[i] = 8'h0;
        end else begin
            if (ptr_wr_en && ptr_sel != PSEL_NONE) begin
                m[26 + 2 * ptr_sel] = ptr_wr_data[7:0];
                m[27 + 2 * ptr_sel] = ptr_wr_data[15:8];
            end
            if (wr_en) m[wr_idx] = wr_data;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; ptr_wr_en = 1'b0;
    endtask

    task automatic all_zero(string tag);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            #1;
            chk(tag, "reset value", {8'h0, rd_a_data}, 16'h0);
        end
    endtask

    initial begin
        #(WD_CYCLES * 10);
        if (!done) begin
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        foreach (m[i]) m[i] = 8'h0;
        @(negedge clk);
        tick("R1");
        rst = 1'b0;
        all_zero("R1");

        // R3 / R4: write and read the same register in one cycle
        wr_en = 1'b1; wr_idx = 5'd5; wr_data = 8'hA5; rd_a_idx = 5'd5;
        #1 chk("R4", "old value", {8'h0, rd_a_data}, 16'h0);
        tick("R4");
        idle();
        #1 chk("R3", "new value", {8'h0, rd_a_data}, 16'h00A5);
        tick("R3");

        // R2: two ports read different registers
        wr_en = 1'b1; wr_idx = 5'd9; wr_data = 8'h3C; tick("R2");
        idle(); rd_a_idx = 5'd5; rd_b_idx = 5'd9;
        #1 chk("R2", "port a", {8'h0, rd_a_data}, 16'h00A5);
        chk("R2", "port b", {8'h0, rd_b_data}, 16'h003C);
        tick("R2");

        // R5 / R6: pointer write to the middle pair
        ptr_sel = PSEL_MID; ptr_wr_en = 1'b1; ptr_wr_data = 16'h1234; tick("R6");
        idle(); rd_a_idx = 5'd28; rd_b_idx = 5'd29;
        #1 chk("R6", "low byte", {8'h0, rd_a_data}, 16'h0034);
        chk("R6", "high byte", {8'h0, rd_b_data}, 16'h0012);
        chk("R5", "pair read", ptr_rd_data, 16'h1234);
        tick("R5");
        ptr_sel = PSEL_LOW; ptr_wr_en = 1'b1; ptr_wr_data = 16'hCAFE; tick("R5");
        idle();
        #1 chk("R5", "low pair", ptr_rd_data, 16'hCAFE);
        tick("R5");

        // R7: no-pair code
        ptr_sel = PSEL_NONE; ptr_wr_en = 1'b1; ptr_wr_data = 16'hFFFF;
        #1 chk("R7", "none read", ptr_rd_data, 16'h0);
        tick("R7");
        idle(); ptr_sel = PSEL_MID;
        #1 chk("R7", "mid unchanged", ptr_rd_data, 16'h1234);
        ptr_sel = PSEL_LOW;
        #1 chk("R7", "low unchanged", ptr_rd_data, 16'hCAFE);
        chk("R7", "top unchanged", prog_addr, 16'h0);
        tick("R7");

        // R8 / R9: collision on the top pair, pointer select elsewhere afterwards
        ptr_sel = PSEL_HIGH; ptr_wr_en = 1'b1; ptr_wr_data = 16'hBEEF;
        wr_en = 1'b1; wr_idx = 5'd31; wr_data = 8'h77; tick("R8");
        idle(); ptr_sel = PSEL_LOW; rd_a_idx = 5'd31; rd_b_idx = 5'd30;
        #1 chk("R8", "byte wins", {8'h0, rd_a_data}, 16'h0077);
        chk("R8", "partner", {8'h0, rd_b_data}, 16'h00EF);
        chk("R9", "prog addr", prog_addr, 16'h77EF);
        tick("R9");

        // R10: random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            rd_a_idx    = 5'($urandom);
            rd_b_idx    = 5'($urandom);
            wr_en       = ($urandom % 2) == 0;
            wr_idx      = ($urandom % 3 == 0) ? 5'(24 + $urandom % 8) : 5'($urandom);
            wr_data     = 8'($urandom);
            ptr_sel     = 2'($urandom);
            ptr_wr_en   = ($urandom % 3) == 0;
            ptr_wr_data = 16'($urandom);
            tick("R10");
        end

        // R1: reset in mid-run
        idle(); rst = 1'b1; tick("R1");
        rst = 1'b0;
        all_zero("R1");
        ptr_sel = PSEL_HIGH;
        #1 chk("R1", "ptr", ptr_rd_data, 16'h0);
        chk("R1", "prog", prog_addr, 16'h0);
        tick("R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule